// File: doc/BRIEF.md
# Bidirectional Row-Scan Shift Register

This block is the row-scan path of a display driver that can run as either a column or a row driver. It is a chain of stages that moves a single scan bit from one row to the next. The bit moves on each falling edge of an external scan clock. Each stage drives the select data for its own row output. A frame-start bit enters at one end pin. The bit that falls off the far end is presented on the opposite end pin, so several devices can be chained into one tall scan.

A direction input chooses the roles of the two end pins. With direction low, the left pin takes data in, the bit walks from stage 0 toward the last stage, and it leaves on the right pin. With direction high, the right pin takes data in, the bit walks from the last stage toward stage 0, and it leaves on the left pin.

Each end pin carries three signals: a separate input value, an output value and an output-enable. The scan clock and the data pins are sampled by the fabric clock, and every output comes from a register.

Top module: `row_scan_top`

## Requirements
- R1: A synchronous active-high reset clears every stage to 0, and both end-pin output values read 0.
- R2: The stages change only when the sampled scan clock falls from 1 to 0. A rising edge, a steady level, or a change of data or direction without a falling edge leaves every stage unchanged.
- R3: With the direction input at 0, a falling edge loads the left input into stage 0 (row 1) and moves the old content of stage i into stage i+1.
- R4: With the direction input at 0, the right pin's output-enable is 1, the left pin's output-enable is 0, the right output value equals the last stage, and the left output value is 0.
- R5: With the direction input at 1, a falling edge loads the right input into the last stage (the highest row) and moves the old content of stage i into stage i-1.
- R6: With the direction input at 1, the left pin's output-enable is 1, the right pin's output-enable is 0, the left output value equals stage 0, and the right output value is 0.
- R7: Bit i of the row-select bus is the content of stage i, where bit 0 is row 1.
- R8: A 1 injected at the input pin appears on the output pin after exactly STAGES falling edges, and it is gone one falling edge later when zeros follow it.
- R9: The input value of the pin that is currently acting as the output has no effect on the stages.
- R10: At no time are both end-pin output-enables high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples all inputs |
| rst | input | 1 | Synchronous reset, active high |
| scan_clk | input | 1 | Row shift clock; a falling edge advances the scan |
| scan_dir | input | 1 | 0: left in, right out; 1: right in, left out |
| left_in | input | 1 | Input value of the left end pin |
| right_in | input | 1 | Input value of the right end pin |
| left_out | output | 1 | Output value of the left end pin |
| left_oe | output | 1 | Output-enable of the left end pin |
| right_out | output | 1 | Output value of the right end pin |
| right_oe | output | 1 | Output-enable of the right end pin |
| row_sel | output | STAGES | Row-select data, bit i is stage i |

## Verification
The bench builds the block with STAGES set to 12 instead of the default 80. With that depth, a single bit can be walked across the whole chain and out of the far pin within a few dozen scan edges. That covers the exact edge on which the bit arrives at the output pin and the edge on which it leaves. It also leaves time to reverse direction in the middle of a pattern and to confirm that the bits already stored are not disturbed.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  typedef struct packed {
    logic val;
    logic oe;
  } pin_drive_t;

  typedef enum logic {
    SCAN_FWD = 1'b0,
    SCAN_REV = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/row_scan_sampler.sv
module row_scan_sampler (
  input  logic clk,
  input  logic rst,
  input  logic scan_clk,
  input  logic dir_in,
  input  logic lin,
  input  logic rin,
  output logic shift_en,
  output logic dir_q,
  output logic lin_q,
  output logic rin_q
);
  logic clk_s1, clk_s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_s1 <= 1'b0;
      clk_s2 <= 1'b0;
      dir_q  <= 1'b0;
      lin_q  <= 1'b0;
      rin_q  <= 1'b0;
    end else begin
      clk_s1 <= scan_clk;
      clk_s2 <= clk_s1;
      dir_q  <= dir_in;
      lin_q  <= lin;
      rin_q  <= rin;
    end
  end

  assign shift_en = clk_s2 & ~clk_s1;

  // R2: a falling edge yields a one-cycle advance pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> !shift_en);
endmodule

// File: rtl/row_scan_chain.sv
module row_scan_chain #(
  parameter int STAGES = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              dir,
  input  logic              lin,
  input  logic              rin,
  output logic [STAGES-1:0] stage
);
  localparam int LAST = STAGES - 1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic from_low, from_high;
    if (i == 0) begin : g_first
      assign from_low = lin;
    end else begin : g_mid_lo
      assign from_low = stage[i-1];
    end
    if (i == LAST) begin : g_last
      assign from_high = rin;
    end else begin : g_mid_hi
      assign from_high = stage[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst)           stage[i] <= 1'b0;
      else if (shift_en) stage[i] <= dir ? from_high : from_low;
    end
  end

  a_r1_clear: assert property (@(posedge clk)
    rst |=> (stage == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(stage));

  a_r3_entry: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !dir) |=> (stage[0] == $past(lin)));

  a_r3_move: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !dir) |=> (stage[LAST:1] == $past(stage[LAST-1:0])));

  a_r5_entry: assert property (@(posedge clk) disable iff (rst)
    (shift_en && dir) |=> (stage[LAST] == $past(rin)));

  a_r5_move: assert property (@(posedge clk) disable iff (rst)
    (shift_en && dir) |=> (stage[LAST-1:0] == $past(stage[LAST:1])));
endmodule

// File: rtl/row_scan_pins.sv
module row_scan_pins
  import row_scan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dir,
  input  logic first_stage,
  input  logic last_stage,
  output pin_drive_t left_pin,
  output pin_drive_t right_pin
);
  always_ff @(posedge clk) begin
    if (rst) begin
      left_pin  <= '{val: 1'b0, oe: 1'b0};
      right_pin <= '{val: 1'b0, oe: 1'b0};
    end else if (scan_dir_e'(dir) == SCAN_REV) begin
      left_pin  <= '{val: first_stage, oe: 1'b1};
      right_pin <= '{val: 1'b0, oe: 1'b0};
    end else begin
      left_pin  <= '{val: 1'b0, oe: 1'b0};
      right_pin <= '{val: last_stage, oe: 1'b1};
    end
  end

  a_r10_oe_exclusive: assert property (@(posedge clk)
    $onehot0({left_pin.oe, right_pin.oe}));

  // R4/R6: a pin that is not driving presents 0
  a_r4_idle_left_low: assert property (@(posedge clk) disable iff (rst)
    !left_pin.oe |-> !left_pin.val);
  a_r6_idle_right_low: assert property (@(posedge clk) disable iff (rst)
    !right_pin.oe |-> !right_pin.val);
endmodule

// File: rtl/row_scan_top.sv
module row_scan_top
  import row_scan_pkg::*;
#(
  parameter int STAGES = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_clk,
  input  logic              scan_dir,
  input  logic              left_in,
  input  logic              right_in,
  output logic              left_out,
  output logic              left_oe,
  output logic              right_out,
  output logic              right_oe,
  output logic [STAGES-1:0] row_sel
);
  logic shift_en, dir_q, lin_q, rin_q;
  logic [STAGES-1:0] stage;
  pin_drive_t left_pin, right_pin;

  row_scan_sampler u_sampler (
    .clk(clk), .rst(rst), .scan_clk(scan_clk), .dir_in(scan_dir),
    .lin(left_in), .rin(right_in),
    .shift_en(shift_en), .dir_q(dir_q), .lin_q(lin_q), .rin_q(rin_q)
  );

  row_scan_chain #(.STAGES(STAGES)) u_chain (
    .clk(clk), .rst(rst), .shift_en(shift_en), .dir(dir_q),
    .lin(lin_q), .rin(rin_q), .stage(stage)
  );

  row_scan_pins u_pins (
    .clk(clk), .rst(rst), .dir(dir_q),
    .first_stage(stage[0]), .last_stage(stage[STAGES-1]),
    .left_pin(left_pin), .right_pin(right_pin)
  );

  assign row_sel   = stage;
  assign left_out  = left_pin.val;
  assign left_oe   = left_pin.oe;
  assign right_out = right_pin.val;
  assign right_oe  = right_pin.oe;
endmodule

// File: tb/row_scan_top_tb_top.sv
module row_scan_top_tb_top;
  localparam int N = 12;
  localparam int NV = 24;
  // each entry: {scan_dir, left_in, right_in}
  localparam logic [2:0] STIM [NV] = '{
    3'b010, 3'b000, 3'b010, 3'b011, 3'b000, 3'b010, 3'b110, 3'b101,
    3'b101, 3'b100, 3'b111, 3'b100, 3'b010, 3'b001, 3'b010, 3'b010,
    3'b000, 3'b101, 3'b100, 3'b110, 3'b101, 3'b011, 3'b000, 3'b010
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, scan_clk, scan_dir, left_in, right_in;
  logic left_out, left_oe, right_out, right_oe;
  logic [N-1:0] row_sel;
  logic [N-1:0] model;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  row_scan_top #(.STAGES(N)) dut_i (
    .clk(clk), .rst(rst), .scan_clk(scan_clk), .scan_dir(scan_dir),
    .left_in(left_in), .right_in(right_in),
    .left_out(left_out), .left_oe(left_oe),
    .right_out(right_out), .right_oe(right_oe), .row_sel(row_sel)
  );

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // full falling-then-rising scan clock pulse; model follows R3/R5
  task automatic scan_pulse();
    scan_clk = 1'b0;
    wait_cyc(4);
    if (!scan_dir) model = {model[N-2:0], left_in};
    else           model = {right_in, model[N-1:1]};
    scan_clk = 1'b1;
    wait_cyc(3);
  endtask

  task automatic check_all(input string tag);
    cmp({tag, " R7 row_sel"}, 32'(row_sel), 32'(model));
    if (!scan_dir) begin
      cmp({tag, " R4 pins"}, {28'd0, right_out, right_oe, left_out, left_oe},
          {28'd0, model[N-1], 1'b1, 1'b0, 1'b0});
    end else begin
      cmp({tag, " R6 pins"}, {28'd0, right_out, right_oe, left_out, left_oe},
          {28'd0, 1'b0, 1'b0, model[0], 1'b1});
    end
    cmp({tag, " R10 oe"}, 32'(left_oe & right_oe), 32'd0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    model = '0;
    wait_cyc(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; scan_clk = 1'b1; scan_dir = 1'b0; left_in = 1'b0; right_in = 1'b0;
    model = '0;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(3);
    cmp("R1 reset row_sel", 32'(row_sel), 32'd0);
    cmp("R1 reset out values", {30'd0, left_out, right_out}, 32'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      {scan_dir, left_in, right_in} = STIM[v];
      wait_cyc(3);
      scan_pulse();
      check_all("R3/R5 table");
    end

    // R2: level and rising edge do nothing
    scan_dir = 1'b0; left_in = 1'b1; right_in = 1'b1;
    wait_cyc(6);
    check_all("R2 steady high");
    scan_clk = 1'b0;
    wait_cyc(4);
    model = {model[N-2:0], 1'b1};
    left_in = 1'b0;
    wait_cyc(6);
    check_all("R2 steady low");
    scan_clk = 1'b1;
    wait_cyc(6);
    check_all("R2 rising edge");
    scan_dir = 1'b1;
    wait_cyc(6);
    check_all("R2 direction change alone");

    // R9: the output pin's input value is ignored
    scan_dir = 1'b0; left_in = 1'b0; right_in = 1'b1;
    wait_cyc(3);
    scan_pulse();
    cmp("R9 fwd ignores right_in", 32'(row_sel[0]), 32'd0);
    check_all("R9 fwd");
    scan_dir = 1'b1; left_in = 1'b1; right_in = 1'b0;
    wait_cyc(3);
    scan_pulse();
    cmp("R9 rev ignores left_in", 32'(row_sel[N-1]), 32'd0);
    check_all("R9 rev");

    // R1: reset during operation
    do_reset();
    cmp("R1 mid-run reset", 32'(row_sel), 32'd0);
    cmp("R1 mid-run outs", {30'd0, left_out, right_out}, 32'd0);

    // R8: forward traversal
    scan_dir = 1'b0; left_in = 1'b1; right_in = 1'b0;
    wait_cyc(3);
    scan_pulse();
    left_in = 1'b0;
    for (int k = 1; k < N; k++) begin
      if (k == N - 1) cmp("R8 fwd not early", 32'(right_out), 32'd0);
      scan_pulse();
    end
    cmp("R8 fwd arrives after STAGES edges", 32'(right_out), 32'd1);
    check_all("R8 fwd");
    scan_pulse();
    cmp("R8 fwd gone", 32'(right_out), 32'd0);

    // R8: reverse traversal
    do_reset();
    scan_dir = 1'b1; right_in = 1'b1; left_in = 1'b0;
    wait_cyc(3);
    scan_pulse();
    cmp("R5 enters top stage", 32'(row_sel), 32'(1 << (N - 1)));
    right_in = 1'b0;
    for (int k = 1; k < N; k++) scan_pulse();
    cmp("R8 rev arrives after STAGES edges", 32'(left_out), 32'd1);
    check_all("R8 rev");
    scan_pulse();
    cmp("R8 rev gone", 32'(left_out), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule